// File: doc/BRIEF.md
# Region-boundary transfer splitter

The block accepts one linear copy request (source address, destination address, byte length) over a valid/ready handshake. It hands a sequence of sub-requests to a single downstream copy engine, cut so that no sub-request crosses a region boundary. Boundaries sit at `WIN_START + k * REGION_BYTES` for every address in the managed window `[WIN_START, WIN_END)`. `REGION_BYTES` is a power of two.

The cut is decided on the destination address. The source address advances by the same byte count as the destination. A request whose destination is outside the window, or that already fits in its region, passes through unchanged as one sub-request.

Control is a two-state machine:
- **ST_IDLE** presents the first clipped piece directly from the input in the same cycle.
  - Transition *IDLE→BUSY*: the first piece is accepted and it is not the last piece.
  - Otherwise the machine stays in ST_IDLE.
- **ST_BUSY** walks the remaining regions.
  - Transition *BUSY→IDLE*: the final piece is accepted downstream.

The engine pulses `piece_done` once per finished sub-request. The block raises `req_done` once, when the last outstanding piece of the request completes. A new request is not accepted until then.

Top module: `region_splitter`

## Requirements
- R1: Any piece whose destination lies in `[WIN_START, WIN_END)` satisfies `((out_dst - WIN_START) mod REGION_BYTES) + out_len <= REGION_BYTES`.
- R2: Each piece's length is the smaller of two values: the bytes still to issue, and the distance from its destination to the next boundary. The pieces of one request sum to its length.
- R3: A request whose destination is outside the window, or whose bytes fit before the next boundary, is issued as exactly one piece equal to the input. `in_ready` is high in the same cycle and the state stays ST_IDLE.
- R4: In ST_IDLE with no request open, `out_valid` equals `in_valid` in the same cycle. The first piece carries `in_src` and `in_dst`, and `in_ready` equals `out_ready`.
- R5: In ST_BUSY, `in_ready` is low and `out_valid` is high. Each piece's source and destination equal the previous piece's source and destination plus the previous length.
- R6: In ST_BUSY, while `out_ready` is low, the presented piece (source, destination, length) holds stable.
- R7: The machine returns to ST_IDLE when the final piece is accepted. `req_done` is a one-cycle pulse in the same cycle as the `piece_done` of the last outstanding piece of the request.
- R8: While any piece of an accepted request has not completed, `in_ready` is low.
- R9: After reset, with `in_valid` low, `out_valid` and `req_done` are low and `in_ready` follows `out_ready`.
- R10: A request that runs past `WIN_END` is cut at `WIN_END`. The bytes beyond `WIN_END` are issued as one piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request taken |
| in_src | input | ADDR_W | Request source address |
| in_dst | input | ADDR_W | Request destination address |
| in_len | input | ADDR_W | Request length in bytes |
| out_valid | output | 1 | Piece offered to engine |
| out_ready | input | 1 | Engine takes piece |
| out_src | output | ADDR_W | Piece source address |
| out_dst | output | ADDR_W | Piece destination address |
| out_len | output | ADDR_W | Piece length in bytes |
| piece_done | input | 1 | Engine finished one piece |
| req_done | output | 1 | Whole request finished |

## Verification
How a wrong internal state shows at the ports:
- **Stale walk address.** The next presented piece is not contiguous with the one just accepted. This is visible in the very next cycle.
- **Wrong remaining-byte count.** The piece length is wrong, or the machine stays in ST_BUSY, so `in_ready` stays low. This is visible on the next accepted piece.
- **Miscounted outstanding pieces.** `req_done` fires on the wrong `piece_done`, or never. New requests then stay blocked, which shows at the end of that request.

A reference model in the bench predicts every port on every clock, so any such divergence is flagged in the cycle it appears.

// File: rtl/region_split_pkg.sv
package region_split_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } split_state_e;
endpackage

// File: rtl/region_clip.sv
// Computes the byte count of one piece from its destination and what remains.
module region_clip #(
    parameter int                 ADDR_W       = 32,
    parameter int                 REGION_BYTES = 64,
    parameter logic [ADDR_W-1:0]  WIN_START    = 32'h0000_1000,
    parameter logic [ADDR_W-1:0]  WIN_END      = 32'h0000_2000
) (
    input  logic [ADDR_W-1:0] cur_dst,
    input  logic [ADDR_W-1:0] rem_len,
    output logic [ADDR_W-1:0] piece_len,
    output logic              piece_last
);
    localparam logic [ADDR_W-1:0] REG_SZ   = ADDR_W'(REGION_BYTES);
    localparam logic [ADDR_W-1:0] REG_MASK = REG_SZ - ADDR_W'(1);

    logic              in_win;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] room;

    always_comb begin
        in_win = (cur_dst >= WIN_START) && (cur_dst < WIN_END);
        offset = (cur_dst - WIN_START) & REG_MASK;
        room   = REG_SZ - offset;
        if (!in_win || (rem_len <= room)) begin
            piece_len  = rem_len;
            piece_last = 1'b1;
        end else begin
            piece_len  = room;
            piece_last = 1'b0;
        end
    end
endmodule

// File: rtl/cmpl_tracker.sv
// Counts pieces in flight and reports completion of the whole request.
module cmpl_tracker #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic issue,
    input  logic final_issue,
    input  logic piece_done,
    output logic open,
    output logic req_done
);
    logic [CNT_W-1:0] pend;
    logic             all_sent;

    assign req_done = open && all_sent && piece_done && (pend == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            unique case ({issue, piece_done})
                2'b10:   pend <= pend + CNT_W'(1);
                2'b01:   pend <= pend - CNT_W'(1);
                default: pend <= pend;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open     <= 1'b0;
            all_sent <= 1'b0;
        end else begin
            if (start)            open     <= 1'b1;
            else if (req_done)    open     <= 1'b0;
            if (final_issue)      all_sent <= 1'b1;
            else if (req_done)    all_sent <= 1'b0;
        end
    end
endmodule

// File: rtl/region_splitter.sv
module region_splitter
    import region_split_pkg::*;
#(
    parameter int                 ADDR_W       = 32,
    parameter int                 REGION_BYTES = 64,
    parameter logic [ADDR_W-1:0]  WIN_START    = 32'h0000_1000,
    parameter logic [ADDR_W-1:0]  WIN_END      = 32'h0000_2000,
    parameter int                 CNT_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_src,
    input  logic [ADDR_W-1:0] in_dst,
    input  logic [ADDR_W-1:0] in_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_src,
    output logic [ADDR_W-1:0] out_dst,
    output logic [ADDR_W-1:0] out_len,
    input  logic              piece_done,
    output logic              req_done
);
    split_state_e      state, state_n;
    logic [ADDR_W-1:0] cur_src, cur_dst, rem_len;
    logic [ADDR_W-1:0] sel_dst, sel_len, piece_len;
    logic              piece_last;
    logic              cmpl_open;
    logic              out_fire, in_fire;

    always_comb begin
        sel_dst = (state == ST_BUSY) ? cur_dst : in_dst;
        sel_len = (state == ST_BUSY) ? rem_len : in_len;
    end

    region_clip #(
        .ADDR_W       (ADDR_W),
        .REGION_BYTES (REGION_BYTES),
        .WIN_START    (WIN_START),
        .WIN_END      (WIN_END)
    ) u_clip (
        .cur_dst    (sel_dst),
        .rem_len    (sel_len),
        .piece_len  (piece_len),
        .piece_last (piece_last)
    );

    // Output decode per state
    always_comb begin
        out_len = piece_len;
        unique case (state)
            ST_IDLE: begin
                out_valid = in_valid && !cmpl_open;
                in_ready  = out_ready && !cmpl_open;
                out_src   = in_src;
                out_dst   = in_dst;
            end
            ST_BUSY: begin
                out_valid = 1'b1;
                in_ready  = 1'b0;
                out_src   = cur_src;
                out_dst   = cur_dst;
            end
            default: begin
                out_valid = 1'b0;
                in_ready  = 1'b0;
                out_src   = in_src;
                out_dst   = in_dst;
            end
        endcase
    end

    assign out_fire = out_valid && out_ready;
    assign in_fire  = in_valid && in_ready;

    // Next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (in_fire && !piece_last)   state_n = ST_BUSY;
            ST_BUSY: if (out_fire && piece_last)   state_n = ST_IDLE;
            default:                               state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Walk registers: next piece follows the accepted one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_src <= '0;
            cur_dst <= '0;
            rem_len <= '0;
        end else if (out_fire) begin
            cur_src <= out_src + piece_len;
            cur_dst <= out_dst + piece_len;
            rem_len <= sel_len - piece_len;
        end
    end

    cmpl_tracker #(
        .CNT_W (CNT_W)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (in_fire),
        .issue       (out_fire),
        .final_issue (out_fire && piece_last),
        .piece_done  (piece_done),
        .open        (cmpl_open),
        .req_done    (req_done)
    );
endmodule

// File: rtl/region_splitter_chk.sv
module region_splitter_chk
    import region_split_pkg::*;
#(
    parameter int                 ADDR_W       = 32,
    parameter int                 REGION_BYTES = 64,
    parameter logic [ADDR_W-1:0]  WIN_START    = 32'h0000_1000,
    parameter logic [ADDR_W-1:0]  WIN_END      = 32'h0000_2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_src,
    input logic [ADDR_W-1:0] out_dst,
    input logic [ADDR_W-1:0] out_len,
    input logic              piece_done,
    input logic              req_done,
    input logic              cmpl_open,
    input split_state_e      state
);
    localparam logic [ADDR_W-1:0] REG_SZ = ADDR_W'(REGION_BYTES);

    logic              chk_in_win;
    logic [ADDR_W-1:0] chk_off;
    assign chk_in_win = (out_dst >= WIN_START) && (out_dst < WIN_END);
    assign chk_off    = (out_dst - WIN_START) & (REG_SZ - ADDR_W'(1));

    p_piece_in_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && chk_in_win) |-> (({1'b0, chk_off} + {1'b0, out_len}) <= {1'b0, REG_SZ}));

    p_first_piece_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready));

    p_ready_low_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> (!in_ready && out_valid));

    p_contiguous_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> ((state != ST_BUSY) ||
            ((out_dst == $past(out_dst) + $past(out_len)) &&
             (out_src == $past(out_src) + $past(out_len)))));

    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !out_ready) |=>
            (out_valid && $stable(out_dst) && $stable(out_src) && $stable(out_len)));

    p_done_on_completion_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (piece_done && cmpl_open));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    p_no_accept_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_open |-> !in_ready);
endmodule

bind region_splitter region_splitter_chk #(
    .ADDR_W       (ADDR_W),
    .REGION_BYTES (REGION_BYTES),
    .WIN_START    (WIN_START),
    .WIN_END      (WIN_END)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_src    (out_src),
    .out_dst    (out_dst),
    .out_len    (out_len),
    .piece_done (piece_done),
    .req_done   (req_done),
    .cmpl_open  (cmpl_open),
    .state      (state)
);

// File: tb/sim_region_splitter.sv
module sim_region_splitter;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 32;
    localparam int          RB         = 64;
    localparam logic [31:0] WS         = 32'h0000_1000;
    localparam logic [31:0] WE         = 32'h0000_2000;
    localparam int          NDIR       = 6;
    localparam int          NREQ       = NDIR + 40;
    localparam int          WDOG       = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_ready;
    logic [AW-1:0] in_src = '0, in_dst = '0, in_len = '0;
    logic          out_valid, out_ready = 1'b1;
    logic [AW-1:0] out_src, out_dst, out_len;
    logic          piece_done = 1'b0, req_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    region_splitter #(
        .ADDR_W(AW), .REGION_BYTES(RB), .WIN_START(WS), .WIN_END(WE), .CNT_W(8)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_dst(in_dst), .in_len(in_len),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_src(out_src), .out_dst(out_dst), .out_len(out_len),
        .piece_done(piece_done), .req_done(req_done)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] clip(input logic [31:0] dst, input logic [31:0] rem);
        logic [31:0] room;
        if (dst < WS || dst >= WE) return rem;
        room = 32'(RB) - ((dst - WS) % 32'(RB));
        return (rem < room) ? rem : room;
    endfunction

    logic [31:0] rq_src [NREQ];
    logic [31:0] rq_dst [NREQ];
    logic [31:0] rq_len [NREQ];
    int          rq_pcs [NREQ];
    string       rq_tag [NREQ];

    // reference model state
    bit          m_busy = 0, m_open = 0, m_allsent = 0;
    logic [31:0] m_src, m_dst, m_rem;
    int          m_pend = 0;
    int          cur_req = 0, cur_pcs = 0;
    longint      cur_bytes = 0;
    bit          stalled = 0;
    int          done_q[$];

    initial begin
        int ri = 0;
        int ndone = 0;
        int cyc = 0;
        rq_src[0] = 32'h8000; rq_dst[0] = 32'h1030; rq_len[0] = 32'h90;  rq_pcs[0] = 3; rq_tag[0] = "R1";
        rq_src[1] = 32'h9000; rq_dst[1] = 32'h3000; rq_len[1] = 32'h200; rq_pcs[1] = 1; rq_tag[1] = "R3";
        rq_src[2] = 32'hA000; rq_dst[2] = 32'h1040; rq_len[2] = 32'h40;  rq_pcs[2] = 1; rq_tag[2] = "R3";
        rq_src[3] = 32'hB000; rq_dst[3] = 32'h1FF0; rq_len[3] = 32'h40;  rq_pcs[3] = 2; rq_tag[3] = "R10";
        rq_src[4] = 32'hC000; rq_dst[4] = 32'h1000; rq_len[4] = 32'h100; rq_pcs[4] = 4; rq_tag[4] = "R1";
        rq_src[5] = 32'hD000; rq_dst[5] = 32'h0FF0; rq_len[5] = 32'h80;  rq_pcs[5] = 1; rq_tag[5] = "R3";
        for (int i = NDIR; i < NREQ; i++) begin
            rq_src[i] = $urandom;
            rq_dst[i] = 32'h0F00 + $urandom_range(0, 32'h1300);
            rq_len[i] = $urandom_range(0, 300);
            rq_pcs[i] = -1;
            rq_tag[i] = "R2";
        end

        // reset phase
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        chk("R9", "in_ready in reset", longint'(in_ready), 1);
        chk("R9", "out_valid in reset", longint'(out_valid), 0);
        chk("R9", "req_done in reset", longint'(req_done), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        out_ready = 1'b0;
        #(CLK_PERIOD/2 - 1);
        chk("R9", "in_ready follows out_ready", longint'(in_ready), 0);
        chk("R9", "out_valid idle", longint'(out_valid), 0);

        while (ndone < NREQ && cyc < WDOG) begin
            logic        ev, er, ed, elast, fire;
            logic [31:0] es, edst, erem, elen;
            string       tsel;
            @(posedge clk); #1;
            cyc++;
            in_valid = (ri < NREQ);
            if (ri < NREQ) begin
                in_src = rq_src[ri]; in_dst = rq_dst[ri]; in_len = rq_len[ri];
            end
            out_ready = (ri < NDIR) ? ($urandom_range(0, 7) != 0) : ($urandom_range(0, 3) != 0);
            piece_done = 1'b0;
            if (done_q.size() > 0 && done_q[0] <= cyc) begin
                void'(done_q.pop_front());
                piece_done = 1'b1;
            end
            #(CLK_PERIOD/2 - 1);

            if (!m_busy) begin
                ev = in_valid && !m_open; er = out_ready && !m_open;
                es = in_src; edst = in_dst; erem = in_len;
            end else begin
                ev = 1'b1; er = 1'b0;
                es = m_src; edst = m_dst; erem = m_rem;
            end
            elen  = clip(edst, erem);
            elast = (elen == erem);
            ed    = piece_done && m_open && m_allsent && (m_pend == 1);

            tsel = m_busy ? (stalled ? "R6" : "R5") : "R4";
            chk(m_busy ? "R5" : "R4", "out_valid", longint'(out_valid), longint'(ev));
            chk(m_busy ? "R5" : (m_open ? "R8" : "R4"), "in_ready", longint'(in_ready), longint'(er));
            if (ev) begin
                chk(tsel, "out_src", longint'(out_src), longint'(es));
                chk(tsel, "out_dst", longint'(out_dst), longint'(edst));
                chk("R2", "out_len", longint'(out_len), longint'(elen));
            end
            chk("R7", "req_done", longint'(req_done), longint'(ed));

            fire    = ev && out_ready;
            stalled = m_busy && ev && !out_ready;
            if (fire) begin
                if (!m_busy) begin
                    m_open = 1; cur_req = ri; cur_pcs = 0; cur_bytes = 0; ri++;
                end
                cur_pcs++;
                cur_bytes += longint'(elen);
                done_q.push_back(cyc + $urandom_range(1, 4));
                if (elast) begin
                    m_busy = 0; m_allsent = 1;
                end else begin
                    m_busy = 1; m_src = es + elen; m_dst = edst + elen; m_rem = erem - elen;
                end
            end
            m_pend += (fire ? 1 : 0) - (piece_done ? 1 : 0);
            if (ed) begin
                m_open = 0; m_allsent = 0; ndone++;
                chk("R2", "bytes issued", cur_bytes, longint'(rq_len[cur_req]));
                if (rq_pcs[cur_req] >= 0)
                    chk(rq_tag[cur_req], "piece count", longint'(cur_pcs), longint'(rq_pcs[cur_req]));
            end
        end
        if (cyc >= WDOG) begin
            checks++; failures++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", ndone, NREQ);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule